// File: doc/BRIEF.md
# Sub-Warp Packer

This block turns the two-dimensional active mask of one large warp into a sequence of dense, SIMD-width sub-warps. The mask has ROWS rows and LANES columns, one column per SIMD lane. Because each lane's register bank can only be addressed for its own column, a lane may only take a thread from that column. In every cycle each column is searched at the same time, and the lowest eligible row in each column is chosen. The chosen threads form one sub-warp, and their bits are cleared from a working copy of the mask.

A large warp is loaded with its mask, a jump flag and its warp ID. While the working copy still holds set bits, the block drives a stall toward fetch and ignores further loads. A jump produces exactly one sub-warp, and the rest of the mask is dropped. A per-thread busy bit is set when a thread is emitted. It is cleared by a completion pulse that carries that sub-warp's per-lane row IDs and enables. A busy thread is not eligible, so a thread cannot be packed again before its previous sub-warp has finished.

Top module: `subwarp_packer`

## Requirements
- R1: After reset, stall and sw_valid are low and every thread's busy bit is clear.
- R2: Mask bit index r*LANES + c holds row r, column c. Lane c only ever carries a thread from column c, and sw_row field c (bits c*RW upward) gives that thread's row.
- R3: In each column the lowest-numbered row that is both set in the working mask and not busy is chosen. A lane with no such row has sw_en low and sw_row field 0.
- R4: For a non-jump warp, each chosen bit is cleared, so every set thread is emitted exactly once. With no busy threads, the number of sub-warps equals the largest per-column count of set bits.
- R5: A load is accepted only while stall is low. Stall is high from the cycle after acceptance for as long as the working mask is non-empty. A load presented while stall is high has no effect.
- R6: A sub-warp is registered on the clock edge after the one that accepted the load, and after that one per edge while threads are eligible.
- R7: For a jump warp, exactly one sub-warp is emitted, and the working mask is empty after that same edge.
- R8: A load with an all-zero mask emits nothing, and stall stays low.
- R9: An emitted thread is not eligible again until a completion pulse (done_valid) arrives with done_en set for its lane and done_row equal to its row.
- R10: sw_valid is high only when at least one lane is enabled, and sw_warp then carries the warp ID of the warp being packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Present a large warp for packing |
| load_mask | input | ROWS*LANES | Active mask, bit r*LANES+c = row r, column c |
| load_jump | input | 1 | Warp is executing an unconditional jump |
| load_warp | input | WID_W | Large-warp ID |
| sw_valid | output | 1 | A sub-warp is presented |
| sw_en | output | LANES | Per-lane thread enable |
| sw_row | output | LANES*RW | Per-lane row index |
| sw_warp | output | WID_W | Warp ID of the sub-warp |
| stall | output | 1 | Hold fetch; working mask not empty |
| done_valid | input | 1 | Completion pulse for one sub-warp |
| done_en | input | LANES | Lane enables of the completed sub-warp |
| done_row | input | LANES*RW | Row IDs of the completed sub-warp |

## Verification
Stall rises one edge after a load is accepted. The first sub-warp appears one edge after that, and the next sub-warps follow one per edge. A completion pulse driven before an edge frees its threads for the pick made at the following edge. The bench keeps a behavioural model that is advanced on the same edges from the same inputs. It compares every output 2 ns after each rising edge, so each comparison falls in the cycle where the registered result is due. Directed scenarios also count the sub-warps emitted per warp and check stall in the cycle right after a load.

// File: rtl/subwarp_pkg.sv
// Shared helpers for the sub-warp packer.
// Assumes: row counts of at least 1; bit layout row-major, column fastest.
package subwarp_pkg;

    // Width of a row index, never less than one bit.
    function automatic int row_bits(input int rows);
        return (rows > 1) ? $clog2(rows) : 1;
    endfunction

    // Flat bit index of thread (row, col) in the active mask.
    function automatic int thread_idx(input int row, input int col, input int lanes);
        return row * lanes + col;
    endfunction

endpackage

// File: rtl/subwarp_col_pick.sv
// Priority picker for one mask column.
// Finds the lowest-numbered candidate row of its lane.
// Assumes: cand already excludes busy threads; purely combinational.
module subwarp_col_pick #(
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input  logic [ROWS-1:0] cand,
    output logic            hit,
    output logic [RW-1:0]   row
);

    // Scan from the top so the lowest set row wins.
    always_comb begin
        hit = 1'b0;
        row = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (cand[r]) begin
                hit = 1'b1;
                row = RW'(r);
            end
        end
    end

endmodule

// File: rtl/subwarp_busy_track.sv
// Per-thread busy bits.
// A bit is set when its thread is packed into a sub-warp.
// It is cleared by a completion pulse that names the thread's lane and row.
// Assumes: set and clear never target the same thread in one cycle
// (a packed thread is never busy, and a completion only names busy threads).
module subwarp_busy_track
    import subwarp_pkg::*;
#(
    parameter int LANES = 32,
    parameter int ROWS  = 8,
    parameter int RW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ROWS*LANES-1:0] set_vec,
    input  logic                  done_valid,
    input  logic [LANES-1:0]      done_en,
    input  logic [LANES*RW-1:0]   done_row,
    output logic [ROWS*LANES-1:0] busy
);

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int IDX = thread_idx(r, c, LANES);
            logic clr;

            // Completion addresses this thread.
            assign clr = done_valid && done_en[c] &&
                         (done_row[c*RW +: RW] == RW'(r));

            // Hold, set on pack, clear on completion.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    busy[IDX] <= 1'b0;
                else if (set_vec[IDX])
                    busy[IDX] <= 1'b1;
                else if (clr)
                    busy[IDX] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/subwarp_pick_array.sv
// Column-parallel selection over the whole working mask.
// Gives per-lane hits and rows, plus the flat vector of chosen threads.
// Assumes: the layout of subwarp_pkg::thread_idx.
module subwarp_pick_array
    import subwarp_pkg::*;
#(
    parameter int LANES = 32,
    parameter int ROWS  = 8,
    parameter int RW    = 3
) (
    input  logic [ROWS*LANES-1:0] work,
    input  logic [ROWS*LANES-1:0] busy,
    output logic [LANES-1:0]      hit,
    output logic [LANES*RW-1:0]   rows,
    output logic [ROWS*LANES-1:0] pick
);

    for (genvar c = 0; c < LANES; c++) begin : g_col
        logic [ROWS-1:0] cand;
        logic [RW-1:0]   sel;

        // Gather this column's eligible threads.
        for (genvar r = 0; r < ROWS; r++) begin : g_gather
            localparam int IDX = thread_idx(r, c, LANES);
            assign cand[r] = work[IDX] & ~busy[IDX];
            assign pick[IDX] = hit[c] && (sel == RW'(r));
        end

        subwarp_col_pick #(.ROWS(ROWS), .RW(RW)) u_pick (
            .cand (cand),
            .hit  (hit[c]),
            .row  (sel)
        );

        assign rows[c*RW +: RW] = sel;
    end

endmodule

// File: rtl/subwarp_packer.sv
// Sub-warp packer top.
// Holds a working copy of one large warp's mask. Each cycle it emits
// one registered sub-warp of the lowest eligible row per column, and it
// stalls fetch until the copy is empty. A jump warp is finished after
// its first sub-warp.
// Assumes: completions are driven by the execute stage with the lane
// enables and rows that the packer emitted earlier.
module subwarp_packer
    import subwarp_pkg::*;
#(
    parameter int LANES = 32,
    parameter int ROWS  = 8,
    parameter int WID_W = 5,
    localparam int RW   = row_bits(ROWS),
    localparam int NTH  = ROWS * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_valid,
    input  logic [NTH-1:0]      load_mask,
    input  logic                load_jump,
    input  logic [WID_W-1:0]    load_warp,
    output logic                sw_valid,
    output logic [LANES-1:0]    sw_en,
    output logic [LANES*RW-1:0] sw_row,
    output logic [WID_W-1:0]    sw_warp,
    output logic                stall,
    input  logic                done_valid,
    input  logic [LANES-1:0]    done_en,
    input  logic [LANES*RW-1:0] done_row
);

    logic [NTH-1:0]      work_q;
    logic                jump_q;
    logic [WID_W-1:0]    warp_q;
    logic [NTH-1:0]      busy;
    logic [LANES-1:0]    hit;
    logic [LANES*RW-1:0] rows;
    logic [NTH-1:0]      pick;
    logic                any_hit;
    logic                load_take;
    logic [NTH-1:0]      set_vec;

    // Working mask non-empty means fetch must wait.
    assign stall     = |work_q;
    assign load_take = load_valid && !stall;
    assign any_hit   = |hit;
    assign set_vec   = any_hit ? pick : '0;

    subwarp_pick_array #(.LANES(LANES), .ROWS(ROWS), .RW(RW)) u_pick (
        .work (work_q),
        .busy (busy),
        .hit  (hit),
        .rows (rows),
        .pick (pick)
    );

    subwarp_busy_track #(.LANES(LANES), .ROWS(ROWS), .RW(RW)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .done_valid (done_valid),
        .done_en    (done_en),
        .done_row   (done_row),
        .busy       (busy)
    );

    // Working mask: loaded when idle, thinned or dropped after each emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            jump_q <= 1'b0;
            warp_q <= '0;
        end else if (load_take) begin
            work_q <= load_mask;
            jump_q <= load_jump;
            warp_q <= load_warp;
        end else if (any_hit) begin
            work_q <= jump_q ? '0 : (work_q & ~pick);
        end
    end

    // Registered sub-warp output; the warp ID is held between emits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_valid <= 1'b0;
            sw_en    <= '0;
            sw_row   <= '0;
            sw_warp  <= '0;
        end else begin
            sw_valid <= any_hit;
            sw_en    <= hit;
            sw_row   <= rows;
            if (any_hit)
                sw_warp <= warp_q;
        end
    end

endmodule

// File: rtl/subwarp_packer_chk.sv
// Temporal checks on the sub-warp packer, attached by bind.
// Assumes: it is connected to the top's ports and its working-state registers.
module subwarp_packer_chk #(
    parameter int LANES = 32,
    parameter int RW    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stall,
    input logic                sw_valid,
    input logic [LANES-1:0]    sw_en,
    input logic [LANES*RW-1:0] sw_row,
    input logic                jump_q,
    input logic                any_hit
);

    logic [LANES*RW-1:0] en_wide;

    for (genvar c = 0; c < LANES; c++) begin : g_wide
        assign en_wide[c*RW +: RW] = {RW{sw_en[c]}};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sw_valid && !stall));

    // R10
    valid_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> (|sw_en));

    // R10
    idle_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_valid |-> (sw_en == '0));

    // R3
    idle_lane_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_row & ~en_wide) == '0);

    // R6
    emit_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> $past(stall));

    // R7
    jump_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && jump_q && any_hit) |=> !stall);

endmodule

bind subwarp_packer subwarp_packer_chk #(.LANES(LANES), .RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .sw_valid (sw_valid),
    .sw_en    (sw_en),
    .sw_row   (sw_row),
    .jump_q   (jump_q),
    .any_hit  (any_hit)
);

// File: tb/subwarp_packer_test.sv
module subwarp_packer_test;
    localparam int L   = 4;
    localparam int R   = 8;
    localparam int W   = 3;
    localparam int RWB = 3;
    localparam int N   = L * R;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_valid = 1'b0;
    logic [N-1:0]   load_mask = '0;
    logic           load_jump = 1'b0;
    logic [W-1:0]   load_warp = '0;
    logic           sw_valid;
    logic [L-1:0]   sw_en;
    logic [L*RWB-1:0] sw_row;
    logic [W-1:0]   sw_warp;
    logic           stall;
    logic           done_valid = 1'b0;
    logic [L-1:0]   done_en = '0;
    logic [L*RWB-1:0] done_row = '0;

    int errors = 0;
    int checks = 0;
    int emitted = 0;
    int cycles = 0;
    logic [W-1:0] last_warp = '0;
    bit auto_done = 1'b1;

    // behavioural model state
    logic [N-1:0]     m_wm = '0;
    logic [N-1:0]     m_busy = '0;
    logic             m_jump = 1'b0;
    logic [W-1:0]     m_warp = '0;
    logic             m_valid = 1'b0;
    logic [L-1:0]     m_en = '0;
    logic [L*RWB-1:0] m_row = '0;
    logic [W-1:0]     m_swarp = '0;
    logic [L*RWB+L-1:0] doneq[$];

    always #4 clk = ~clk;

    subwarp_packer #(.LANES(L), .ROWS(R), .WID_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_mask(load_mask),
        .load_jump(load_jump), .load_warp(load_warp), .sw_valid(sw_valid),
        .sw_en(sw_en), .sw_row(sw_row), .sw_warp(sw_warp), .stall(stall),
        .done_valid(done_valid), .done_en(done_en), .done_row(done_row)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model advanced on every edge
    always @(posedge clk) begin
        logic [N-1:0] pick;
        logic [L-1:0] hv;
        logic [L*RWB-1:0] rv;
        logic old_stall;
        cycles++;
        if (!rst_n) begin
            m_wm = '0; m_busy = '0; m_jump = 1'b0; m_warp = '0;
            m_valid = 1'b0; m_en = '0; m_row = '0; m_swarp = '0;
        end else begin
            old_stall = |m_wm;
            pick = '0; hv = '0; rv = '0;
            for (int c = 0; c < L; c++)
                for (int r = 0; r < R; r++)
                    if (m_wm[r*L+c] && !m_busy[r*L+c] && !hv[c]) begin
                        hv[c] = 1'b1;
                        rv[c*RWB +: RWB] = RWB'(r);
                        pick[r*L+c] = 1'b1;
                    end
            if (done_valid)
                for (int c = 0; c < L; c++)
                    if (done_en[c]) m_busy[int'(done_row[c*RWB +: RWB])*L+c] = 1'b0;
            m_busy = m_busy | pick;
            m_valid = |hv; m_en = hv; m_row = rv;
            if (|hv) m_swarp = m_warp;
            if (load_valid && !old_stall) begin
                m_wm = load_mask; m_jump = load_jump; m_warp = load_warp;
            end else if (|hv) begin
                m_wm = m_jump ? '0 : (m_wm & ~pick);
            end
        end
    end

    // Per-cycle comparison, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(stall == |m_wm, "R5 stall", stall, |m_wm);
            check(sw_valid == m_valid, "R6 sw_valid", sw_valid, m_valid);
            check(sw_en == m_en, "R3 sw_en", sw_en, m_en);
            check(sw_row == m_row, "R2 sw_row", sw_row, m_row);
            check(sw_warp == m_swarp, "R10 sw_warp", sw_warp, m_swarp);
            if (m_valid) doneq.push_back({m_en, m_row});
            if (sw_valid) begin
                emitted++;
                last_warp = sw_warp;
            end
        end
    end

    // Completion driver replays emitted sub-warps in order (R9)
    always @(negedge clk) begin
        logic [L*RWB+L-1:0] e;
        done_valid = 1'b0;
        if (auto_done && doneq.size() > 0) begin
            e = doneq.pop_front();
            done_valid = 1'b1;
            done_en = e[L*RWB +: L];
            done_row = e[L*RWB-1:0];
        end
    end

    task automatic load_warp_t(input logic [N-1:0] m, input bit j, input logic [W-1:0] w);
        @(negedge clk);
        load_valid = 1'b1; load_mask = m; load_jump = j; load_warp = w;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic drain();
        while (stall) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] sparse;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(stall == 1'b0, "R1 stall", stall, 0);
        check(sw_valid == 1'b0, "R1 sw_valid", sw_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: dense mask needs one sub-warp per row
        emitted = 0;
        load_warp_t('1, 1'b0, 3'd1);
        check(stall == 1'b1, "R5 stall after load", stall, 1);
        drain();
        check(emitted == 8, "R4 dense count", emitted, 8);

        // R4: sparse column counts 3,2,4,1
        sparse = (N'(1) << 0) | (N'(1) << 8) | (N'(1) << 20) | (N'(1) << 5) |
                 (N'(1) << 29) | (N'(1) << 2) | (N'(1) << 14) | (N'(1) << 18) |
                 (N'(1) << 26) | (N'(1) << 27);
        emitted = 0;
        load_warp_t(sparse, 1'b0, 3'd2);
        drain();
        check(emitted == 4, "R4 sparse count", emitted, 4);

        // R7: jump emits once
        emitted = 0;
        load_warp_t('1, 1'b1, 3'd3);
        drain();
        check(emitted == 1, "R7 jump count", emitted, 1);

        // R8: empty mask
        emitted = 0;
        load_warp_t('0, 1'b0, 3'd4);
        check(stall == 1'b0, "R8 stall on empty", stall, 0);
        drain();
        check(emitted == 0, "R8 empty count", emitted, 0);

        // R5: load while stalled is ignored
        emitted = 0;
        load_warp_t('1, 1'b0, 3'd5);
        load_warp_t(N'(1), 1'b1, 3'd6);
        drain();
        check(emitted == 8, "R5 ignored load count", emitted, 8);
        check(last_warp == 3'd5, "R5 ignored load warp", last_warp, 5);

        // R9: busy threads block repacking until completion
        auto_done = 1'b0;
        emitted = 0;
        load_warp_t(N'(4'hF), 1'b0, 3'd1);
        drain();
        check(emitted == 1, "R9 first pack", emitted, 1);
        emitted = 0;
        load_warp_t(N'(4'hF), 1'b0, 3'd2);
        repeat (5) @(negedge clk);
        check(stall == 1'b1, "R9 blocked stall", stall, 1);
        check(emitted == 0, "R9 blocked count", emitted, 0);
        auto_done = 1'b1;
        drain();
        check(emitted == 1, "R9 released count", emitted, 1);
        check(last_warp == 3'd2, "R10 released warp", last_warp, 2);

        // Random warps with random gaps, compared by the model
        for (int i = 0; i < 40; i++) begin
            load_warp_t(N'($urandom), ($urandom % 4) == 0, W'(i));
            if (i % 3 == 0) drain();
            else repeat ($urandom % 6) @(negedge clk);
        end
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule